// File: doc/BRIEF.md
# Receive Buffer Credit Flow Controller

This block counts the receive buffers that software has handed to a DMA receive channel, and asks the receive MAC to pause when buffers run short. Software grants credits by writing a count to an allocation register, or reloads the counter outright by setting a force bit in the same write. The DMA channel pulses `consume` once for every descriptor it fills, and each pulse takes away one credit.

Two programmable thresholds give the pause request hysteresis. The request rises when the credit count drops below the low threshold. It falls again only once the count has climbed to the high threshold. Software usually sets the thresholds to about a third and two thirds of the ring size. Flow control only has an effect while its enable bit in the channel configuration word is set.

Top module: `rx_credit_fc`

## Requirements
- R1: While reset is held and in the first cycle after it, `credit_cnt` is 0 and `pause_req` is 0. Both thresholds and the enable bit also reset to 0.
- R2: A write with `wr_sel`=0 and `wr_data[31]`=0 adds `wr_data[CNT_W-1:0]` to the count. The result saturates at 2^CNT_W-1 and never wraps.
- R3: A write with `wr_sel`=0 and `wr_data[31]`=1 loads the count with `wr_data[CNT_W-1:0]`. A `consume` pulse in the same cycle is dropped.
- R4: A `consume` pulse with no allocation write lowers the count by one. At 0 the count stays at 0.
- R5: An add and a `consume` in the same cycle are both applied in that cycle, giving count+add-1. The result is clamped to the range 0 to 2^CNT_W-1.
- R6: When enabled, `pause_req` is 1 in the cycle after the updated count is below the low threshold.
- R7: When enabled, `pause_req` is 0 in the cycle after the updated count is at or above the high threshold, as long as it is not also below the low threshold.
- R8: When enabled, `pause_req` keeps its value while the updated count lies in the range from low up to, but not including, high.
- R9: `wr_sel`=3 writes the channel configuration, and bit 4 of it is the flow-control enable. While enable is 0, `pause_req` is 0 in the following cycle whatever the count.
- R10: `wr_sel`=1 writes the low threshold and `wr_sel`=2 writes the high threshold, each from `wr_data[CNT_W-1:0]`. A new threshold is used from the next cycle onward. Threshold and configuration writes leave the count alone, apart from any `consume` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 alloc, 1 low, 2 high, 3 config |
| wr_data | input | 32 | Write data |
| consume | input | 1 | One pulse per filled descriptor |
| credit_cnt | output | CNT_W | Current credit count |
| pause_req | output | 1 | Pause request to the receive MAC |

## Verification
The assertions check on every cycle that the counter's steps hold: a decrement stops at zero, a force load wins over a consume, and a plain consume lowers the count by one. They also check that the pause output follows the set, clear, hold and disable rules against the updated count. Some behaviours appear only in the bench's sweeps, which compute the expected count and pause level arithmetically. These are saturation at the top of the range, threshold writes that take effect one cycle late, and the exhaustive grid of threshold pairs against loaded counts.

// File: rtl/rx_credit_pkg.sv
package rx_credit_pkg;
    typedef enum logic [1:0] {
        SEL_ALLOC = 2'd0,
        SEL_LOW   = 2'd1,
        SEL_HIGH  = 2'd2,
        SEL_CFG   = 2'd3
    } reg_sel_e;

    localparam int FORCE_BIT = 31;
    localparam int FC_EN_BIT = 4;
endpackage

// File: rtl/rcf_regs.sv
module rcf_regs
    import rx_credit_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_val,
    input  logic             wr_en_bit,
    output logic [CNT_W-1:0] low_thr,
    output logic [CNT_W-1:0] high_thr,
    output logic             fc_en
);
    typedef struct packed {
        logic [CNT_W-1:0] low;
        logic [CNT_W-1:0] high;
        logic             en;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (reg_sel_e'(wr_sel))
                SEL_LOW:  r_d.low  = wr_val;
                SEL_HIGH: r_d.high = wr_val;
                SEL_CFG:  r_d.en   = wr_en_bit;
                default:  r_d = r_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign low_thr  = r_q.low;
    assign high_thr = r_q.high;
    assign fc_en    = r_q.en;

    // R10
    low_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd1) |=> (low_thr == $past(wr_val)));
endmodule

// File: rtl/rcf_counter.sv
module rcf_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             add_v,
    input  logic             load_v,
    input  logic [CNT_W-1:0] val,
    input  logic             consume,
    output logic [CNT_W-1:0] cnt_next,
    output logic [CNT_W-1:0] cnt
);
    localparam int SUM_W = CNT_W + 1;
    localparam logic [SUM_W-1:0] MAX_V = SUM_W'((1 << CNT_W) - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [SUM_W-1:0] sum;

    always_comb begin
        sum = {1'b0, cnt_q};
        if (add_v) sum = sum + {1'b0, val};
        if (consume && sum != '0) sum = sum - 1'b1;
        if (sum > MAX_V) sum = MAX_V;
        cnt_d = load_v ? val : sum[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_next = cnt_d;
    assign cnt      = cnt_q;

    // R4
    floor_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && cnt == '0 && !add_v && !load_v) |=> (cnt == '0));
    // R4
    dec_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && cnt != '0 && !add_v && !load_v) |=> (cnt == $past(cnt) - 1'b1));
    // R3
    force_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_v |=> (cnt == $past(val)));
endmodule

// File: rtl/rcf_pause.sv
module rcf_pause #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fc_en,
    input  logic [CNT_W-1:0] cnt_upd,
    input  logic [CNT_W-1:0] low_thr,
    input  logic [CNT_W-1:0] high_thr,
    output logic             pause
);
    logic pause_d, pause_q;

    always_comb begin
        pause_d = pause_q;
        if (!fc_en)                 pause_d = 1'b0;
        else if (cnt_upd < low_thr) pause_d = 1'b1;
        else if (cnt_upd >= high_thr) pause_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pause_q <= 1'b0;
        else        pause_q <= pause_d;
    end

    assign pause = pause_q;

    // R9
    disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fc_en |=> !pause);
    // R6
    set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_en && cnt_upd < low_thr) |=> pause);
    // R7
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_en && cnt_upd >= high_thr && cnt_upd >= low_thr) |=> !pause);
    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_en && cnt_upd >= low_thr && cnt_upd < high_thr) |=> $stable(pause));
endmodule

// File: rtl/rx_credit_fc.sv
module rx_credit_fc
    import rx_credit_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [31:0]      wr_data,
    input  logic             consume,
    output logic [CNT_W-1:0] credit_cnt,
    output logic             pause_req
);
    logic [CNT_W-1:0] low_thr, high_thr, cnt_upd;
    logic             fc_en, alloc_wr, add_v, load_v;
    logic             unused_wr_bits;

    assign unused_wr_bits = ^wr_data;
    assign alloc_wr = wr_en && (wr_sel == SEL_ALLOC);
    assign add_v    = alloc_wr && !wr_data[FORCE_BIT];
    assign load_v   = alloc_wr &&  wr_data[FORCE_BIT];

    rcf_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_val(wr_data[CNT_W-1:0]), .wr_en_bit(wr_data[FC_EN_BIT]),
        .low_thr(low_thr), .high_thr(high_thr), .fc_en(fc_en)
    );

    rcf_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .add_v(add_v), .load_v(load_v),
        .val(wr_data[CNT_W-1:0]), .consume(consume),
        .cnt_next(cnt_upd), .cnt(credit_cnt)
    );

    rcf_pause #(.CNT_W(CNT_W)) u_pause (
        .clk(clk), .rst_n(rst_n), .fc_en(fc_en), .cnt_upd(cnt_upd),
        .low_thr(low_thr), .high_thr(high_thr), .pause(pause_req)
    );
endmodule

// File: tb/rx_credit_fc_tb.sv
module rx_credit_fc_tb;
    localparam int CNT_W = 8;
    localparam int MAXV  = (1 << CNT_W) - 1;

    logic clk = 0, rst_n = 0, wr_en = 0, consume = 0;
    logic [1:0] wr_sel = 0;
    logic [31:0] wr_data = 0;
    logic [CNT_W-1:0] credit_cnt;
    logic pause_req;

    int total = 0, bad = 0;
    int m_cnt = 0, m_low = 0, m_high = 0;
    bit m_en = 0, m_pause = 0, done = 0;

    always #4 clk = ~clk;

    rx_credit_fc #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .consume(consume),
        .credit_cnt(credit_cnt), .pause_req(pause_req)
    );

    task automatic check(string tag);
        total++;
        if (int'(credit_cnt) != m_cnt || pause_req != m_pause) begin
            bad++;
            $display("FAIL %s: cnt=%0d pause=%0d expected cnt=%0d pause=%0d",
                     tag, credit_cnt, pause_req, m_cnt, m_pause);
        end
    endtask

    // one cycle: drive, clock, update model, compare
    task automatic step(bit w, int sel, logic [31:0] d, bit c, string tag);
        int nxt;
        wr_en = w; wr_sel = 2'(sel); wr_data = d; consume = c;
        @(posedge clk);
        #1;
        nxt = m_cnt;
        if (w && sel == 0 && d[31]) nxt = int'(d[CNT_W-1:0]);
        else begin
            if (w && sel == 0) nxt = nxt + int'(d[CNT_W-1:0]);
            if (c && nxt > 0) nxt = nxt - 1;
            if (nxt > MAXV) nxt = MAXV;
        end
        if (!m_en) m_pause = 0;
        else if (nxt < m_low) m_pause = 1;
        else if (nxt >= m_high) m_pause = 0;
        m_cnt = nxt;
        if (w && sel == 1) m_low  = int'(d[CNT_W-1:0]);
        if (w && sel == 2) m_high = int'(d[CNT_W-1:0]);
        if (w && sel == 3) m_en   = d[4];
        wr_en = 0; consume = 0;
        check(tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1; check("R1 in reset");
        rst_n = 1;
        step(0, 0, 0, 0, "R1 after reset");
        step(0, 0, 0, 1, "R4 consume at zero");
        step(1, 1, 32'd4, 0, "R10 low write");
        step(1, 2, 32'd8, 0, "R10 high write");
        step(1, 3, 32'h10, 0, "R9 enable");
        step(0, 0, 0, 0, "R6 pause below low");
        for (int i = 0; i < 10; i++) step(1, 0, 32'd1, 0, "R2 R7 R8 add one");
        for (int i = 0; i < 12; i++) step(0, 0, 0, 1, "R4 R6 R8 consume");
        step(1, 0, 32'd5, 1, "R5 add and consume");
        step(1, 0, 32'd0, 1, "R5 zero add and consume");
        step(1, 0, 32'h8000_0009, 1, "R3 force with consume");
        step(1, 0, 32'h8000_00FA, 0, "R3 force high value");
        step(1, 0, 32'd10, 0, "R2 saturate");
        step(1, 0, 32'd1, 1, "R5 at max");
        step(1, 1, 32'hFF, 1, "R10 threshold write keeps count");
        step(0, 0, 0, 0, "R6 new low active");
        step(1, 3, 32'h0, 0, "R9 disable");
        step(1, 0, 32'h8000_0000, 0, "R9 no pause disabled");
        step(1, 3, 32'h10, 0, "R9 re-enable");
        for (int lo = 0; lo < 5; lo++)
            for (int hi = 0; hi < 5; hi++) begin
                step(1, 1, 32'(lo), 0, "R10 sweep low");
                step(1, 2, 32'(hi), 0, "R10 sweep high");
                for (int v = 0; v < 6; v++) begin
                    step(1, 0, 32'h8000_0000 | 32'(v), 0, "R3 R6 R7 R8 sweep");
                    step(0, 0, 0, 1, "R4 R6 R7 R8 sweep consume");
                end
            end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog: expected run to finish");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule